// File: doc/BRIEF.md
# Writeback Pixel Format Packer

This block sits in a display writeback path, between the pixel source and the memory writer. It takes one pixel per cycle as four 8-bit channels (red, green, blue, alpha) and turns the stream into 32-bit memory words, each with a 4-bit byte-strobe. A 4-bit format code chooses the storage size (16, 24 or 32 bits per pixel) and the channel order. Narrow channels keep the most significant bits of each input channel. The alpha byte can be stored as it arrives, stored inverted, or replaced by a constant fill.

Pixels are packed little-endian: the first pixel of a word goes into the lowest byte lanes. 16-bit formats put two pixels in a word. 24-bit formats put four pixels in three words. An end-of-line marker on the last pixel of a line forces out any partly filled word, so each line starts on a fresh word. Both sides use a valid/ready handshake. The configuration inputs must stay constant from the first pixel of a line until the last word of that line has left the block.

Top module: `wbpk_packer`

## Requirements
- R1: During and after reset, `out_valid` and `err_flag` are 0 and `in_ready` is 1.
- R2: Codes 12, 13, 14 and 15 produce one word per pixel. From byte lane 3 down to lane 0 the bytes are A,B,G,R (12), A,R,G,B (13), B,G,R,A (14) and R,G,B,A (15).
- R3: Codes 0–3 store the top 4 bits of each channel in the nibble order A,B,G,R (0), A,R,G,B (1), B,G,R,A (2) and R,G,B,A (3), from bit 15 down to bit 0. Two pixels share a word, and the first pixel goes in bits 15:0.
- R4: Code 6 packs B[7:3],G[7:2],R[7:3], and code 7 packs R[7:3],G[7:2],B[7:3], from bit 15 down to bit 0. Two pixels share a word.
- R5: Codes 8 (bytes B,G,R from high to low) and 9 (R,G,B) take three bytes per pixel, placed in consecutive byte lanes across word boundaries. Four pixels fill exactly three words.
- R6: When a pixel carries `in_eol`, any partly filled word is emitted with strobes only on its filled low lanes and zeros in its unused bytes. The next pixel starts at lane 0.
- R7: When `alpha_keep` is 1, the stored alpha is `in_alpha`, inverted bitwise when `alpha_inv` is 1.
- R8: When `alpha_keep` is 0, the alpha byte or nibble is all ones if `alpha_inv` is 1 and all zeros otherwise. The 565 and 888 formats carry no alpha.
- R9: `out_strb` is the set of filled lanes ANDed with `lane_en`. `out_data` does not depend on `lane_en`.
- R10: Codes 4, 5, 10 and 11 are accepted but produce no output word, and they set `err_flag`. `err_flag` stays at 1 until reset.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_strb` hold their values and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_code | input | 4 | Format code |
| alpha_keep | input | 1 | Store incoming alpha |
| alpha_inv | input | 1 | Invert stored alpha, or select the fill value |
| lane_en | input | 4 | Per-lane store enable |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel accepted when high with `in_valid` |
| in_red | input | 8 | Red channel |
| in_green | input | 8 | Green channel |
| in_blue | input | 8 | Blue channel |
| in_alpha | input | 8 | Alpha channel |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Packed memory word |
| out_strb | output | 4 | Byte strobes |
| err_flag | output | 1 | Sticky flag for an unused format code |

## Verification
Most faults inside this block show up as wrong data in the first affected word. A wrong accumulator count shifts every byte that follows, so in 24-bit mode a single bad update corrupts the next word and every word after it until the end of the line. A flush flag that stays set holds `in_ready` low indefinitely. A flush that is dropped causes the bytes left from one line to appear at the start of the next line's first word, or to go missing.

// File: rtl/wbpk_pkg.sv
package wbpk_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int FMT_W  = 4;
    localparam int CNT_W  = $clog2(LANES);
    localparam int NB_W   = CNT_W + 1;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_16   = 2'd1,
        SZ_24   = 2'd2,
        SZ_32   = 2'd3
    } pix_size_e;

    typedef struct packed {
        logic [BYTE_W-1:0] r;
        logic [BYTE_W-1:0] g;
        logic [BYTE_W-1:0] b;
        logic [BYTE_W-1:0] a;
    } pixel_t;

    function automatic pix_size_e fmt_size(input logic [FMT_W-1:0] code);
        case (code)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd6, 4'd7: fmt_size = SZ_16;
            4'd8, 4'd9:                         fmt_size = SZ_24;
            4'd12, 4'd13, 4'd14, 4'd15:         fmt_size = SZ_32;
            default:                            fmt_size = SZ_NONE;
        endcase
    endfunction

    function automatic logic [NB_W-1:0] size_bytes(input pix_size_e sz);
        case (sz)
            SZ_16:   size_bytes = NB_W'(2);
            SZ_24:   size_bytes = NB_W'(3);
            SZ_32:   size_bytes = NB_W'(4);
            default: size_bytes = '0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] fill_mask(input logic [NB_W-1:0] n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i] = (NB_W'(i) < n);
        end
        fill_mask = m;
    endfunction

endpackage

// File: rtl/wbpk_pixel_fmt.sv
module wbpk_pixel_fmt
    import wbpk_pkg::*;
(
    input  logic [FMT_W-1:0]  code,
    input  pixel_t            pix,
    input  logic              alpha_keep,
    input  logic              alpha_inv,
    output logic [WORD_W-1:0] bytes,
    output logic [NB_W-1:0]   nbytes,
    output logic              bad
);

    logic [BYTE_W-1:0] a_eff;
    logic [BYTE_W-1:0] c_hi;
    logic [BYTE_W-1:0] c_lo;
    logic [WORD_W-1:0] quad;
    logic [WORD_W/2-1:0] nib;
    pix_size_e          sz;

    always_comb begin
        a_eff = alpha_keep ? (pix.a ^ {BYTE_W{alpha_inv}}) : {BYTE_W{alpha_inv}};
        c_hi  = code[0] ? pix.r : pix.b;
        c_lo  = code[0] ? pix.b : pix.r;
        quad  = code[1] ? {c_hi, pix.g, c_lo, a_eff} : {a_eff, c_hi, pix.g, c_lo};
    end

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_nib
            assign nib[gi*(BYTE_W/2) +: BYTE_W/2] = quad[gi*BYTE_W + BYTE_W/2 +: BYTE_W/2];
        end
    endgenerate

    always_comb begin
        sz = fmt_size(code);
        case (sz)
            SZ_32:   bytes = quad;
            SZ_24:   bytes = {{BYTE_W{1'b0}}, c_hi, pix.g, c_lo};
            SZ_16:   bytes = code[2] ? {{(WORD_W/2){1'b0}}, c_hi[7:3], pix.g[7:2], c_lo[7:3]}
                                     : {{(WORD_W/2){1'b0}}, nib};
            default: bytes = '0;
        endcase
        nbytes = size_bytes(sz);
        bad    = (sz == SZ_NONE);
    end

endmodule

// File: rtl/wbpk_byte_gather.sv
module wbpk_byte_gather
    import wbpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              eol,
    input  logic [WORD_W-1:0] pix_bytes,
    input  logic [NB_W-1:0]   pix_n,
    input  logic              out_free,
    output logic              emit,
    output logic [WORD_W-1:0] emit_word,
    output logic [NB_W-1:0]   emit_n,
    output logic              flush_pend
);

    logic [WORD_W-1:0]   acc_q, acc_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                fl_d;
    logic [NB_W-1:0]     tot;
    logic [NB_W-1:0]     rcnt;
    logic [2*WORD_W-1:0] merged;
    logic                full;
    logic [WORD_W-1:0]   rest;

    always_comb begin
        tot    = {1'b0, cnt_q} + pix_n;
        merged = {{WORD_W{1'b0}}, acc_q}
               | ({{WORD_W{1'b0}}, pix_bytes} << {cnt_q, 3'b000});
        full   = (tot >= NB_W'(LANES));
        rest   = full ? merged[2*WORD_W-1:WORD_W] : merged[WORD_W-1:0];
        rcnt   = full ? (tot - NB_W'(LANES)) : tot;

        emit      = 1'b0;
        emit_word = '0;
        emit_n    = '0;
        acc_d     = acc_q;
        cnt_d     = cnt_q;
        fl_d      = flush_pend;

        if (flush_pend) begin
            if (out_free) begin
                emit      = 1'b1;
                emit_word = acc_q;
                emit_n    = {1'b0, cnt_q};
                acc_d     = '0;
                cnt_d     = '0;
                fl_d      = 1'b0;
            end
        end else if (take) begin
            if (full) begin
                emit      = 1'b1;
                emit_word = merged[WORD_W-1:0];
                emit_n    = NB_W'(LANES);
                acc_d     = rest;
                cnt_d     = rcnt[CNT_W-1:0];
                fl_d      = eol && (rcnt != '0);
            end else if (eol && (tot != '0)) begin
                emit      = 1'b1;
                emit_word = merged[WORD_W-1:0];
                emit_n    = tot;
                acc_d     = '0;
                cnt_d     = '0;
            end else begin
                acc_d     = rest;
                cnt_d     = rcnt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            cnt_q      <= '0;
            flush_pend <= 1'b0;
        end else begin
            acc_q      <= acc_d;
            cnt_q      <= cnt_d;
            flush_pend <= fl_d;
        end
    end

endmodule

// File: rtl/wbpk_out_stage.sv
module wbpk_out_stage
    import wbpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic [NB_W-1:0]   nbytes,
    input  logic [LANES-1:0]  lane_en,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_strb,
    output logic              free
);

    assign free = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_strb  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= word;
            out_strb  <= fill_mask(nbytes) & lane_en;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/wbpk_packer.sv
module wbpk_packer
    import wbpk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FMT_W-1:0]   fmt_code,
    input  logic               alpha_keep,
    input  logic               alpha_inv,
    input  logic [LANES-1:0]   lane_en,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BYTE_W-1:0]  in_red,
    input  logic [BYTE_W-1:0]  in_green,
    input  logic [BYTE_W-1:0]  in_blue,
    input  logic [BYTE_W-1:0]  in_alpha,
    input  logic               in_eol,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_data,
    output logic [LANES-1:0]   out_strb,
    output logic               err_flag
);

    pixel_t            pix;
    logic [WORD_W-1:0] pix_bytes;
    logic [NB_W-1:0]   pix_n;
    logic              pix_bad;
    logic              take;
    logic              out_free;
    logic              busy;
    logic              emit_w;
    logic [WORD_W-1:0] emit_word;
    logic [NB_W-1:0]   emit_n;

    assign pix      = '{r: in_red, g: in_green, b: in_blue, a: in_alpha};
    assign in_ready = !busy && out_free;
    assign take     = in_valid && in_ready;

    wbpk_pixel_fmt u_fmt (
        .code       (fmt_code),
        .pix        (pix),
        .alpha_keep (alpha_keep),
        .alpha_inv  (alpha_inv),
        .bytes      (pix_bytes),
        .nbytes     (pix_n),
        .bad        (pix_bad)
    );

    wbpk_byte_gather u_gather (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .eol        (in_eol),
        .pix_bytes  (pix_bytes),
        .pix_n      (pix_n),
        .out_free   (out_free),
        .emit       (emit_w),
        .emit_word  (emit_word),
        .emit_n     (emit_n),
        .flush_pend (busy)
    );

    wbpk_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (emit_w),
        .word      (emit_word),
        .nbytes    (emit_n),
        .lane_en   (lane_en),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_strb  (out_strb),
        .free      (out_free)
    );

    always_ff @(posedge clk) begin
        if (rst)                 err_flag <= 1'b0;
        else if (take && pix_bad) err_flag <= 1'b1;
    end

endmodule

// File: rtl/wbpk_packer_chk.sv
module wbpk_packer_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  fmt_code,
    input logic [3:0]  lane_en,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic [3:0]  out_strb,
    input logic        err_flag,
    input logic        emit
);

    logic code_unused;
    assign code_unused = (fmt_code == 4'd4) || (fmt_code == 4'd5) ||
                         (fmt_code == 4'd10) || (fmt_code == 4'd11);

    // R1: reset clears the output and the error flag
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !err_flag));

    // R9: loaded strobes never enable a lane that lane_en masks off
    p_strb_lane_r9: assert property (@(posedge clk) disable iff (rst)
        emit |=> ((out_strb & ~$past(lane_en)) == 4'd0));

    // R11: a stalled word is held unchanged
    p_hold_word_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_strb)));

    // R11: no pixel is taken while the output is stalled
    p_stall_input_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R10: an accepted pixel with an unused code raises the flag
    p_bad_sets_err_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && code_unused) |=> err_flag);

    // R10: the flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

endmodule

bind wbpk_packer wbpk_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fmt_code  (fmt_code),
    .lane_en   (lane_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_strb  (out_strb),
    .err_flag  (err_flag),
    .emit      (emit_w)
);

// File: tb/wbpk_packer_tb.sv
`timescale 1ns/1ps
module wbpk_packer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  fmt_code = 4'd12;
    logic        alpha_keep = 1'b0;
    logic        alpha_inv = 1'b0;
    logic [3:0]  lane_en = 4'hF;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_red = '0, in_green = '0, in_blue = '0, in_alpha = '0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_strb;
    logic        err_flag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit hold_ready = 1'b0;
    bit done = 1'b0;

    logic [7:0]  bq[$];
    logic [31:0] exp_data[$];
    logic [3:0]  exp_strb[$];
    string       exp_tag[$];

    wbpk_packer u_dut (
        .clk(clk), .rst(rst), .fmt_code(fmt_code), .alpha_keep(alpha_keep),
        .alpha_inv(alpha_inv), .lane_en(lane_en), .in_valid(in_valid),
        .in_ready(in_ready), .in_red(in_red), .in_green(in_green),
        .in_blue(in_blue), .in_alpha(in_alpha), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_strb(out_strb), .err_flag(err_flag)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ref_bytes(input int code, input logic [7:0] r, g, b, a);
        case (code)
            0:  return {16'h0, a[7:4], b[7:4], g[7:4], r[7:4]};
            1:  return {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]};
            2:  return {16'h0, b[7:4], g[7:4], r[7:4], a[7:4]};
            3:  return {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]};
            6:  return {16'h0, b[7:3], g[7:2], r[7:3]};
            7:  return {16'h0, r[7:3], g[7:2], b[7:3]};
            8:  return {8'h0, b, g, r};
            9:  return {8'h0, r, g, b};
            12: return {a, b, g, r};
            13: return {a, r, g, b};
            14: return {b, g, r, a};
            15: return {r, g, b, a};
            default: return 32'h0;
        endcase
    endfunction

    function automatic int ref_n(input int code);
        if (code <= 3 || code == 6 || code == 7) return 2;
        if (code == 8 || code == 9) return 3;
        if (code >= 12) return 4;
        return 0;
    endfunction

    function automatic string full_tag(input int code);
        if (lane_en != 4'hF) return "R9";
        if (code <= 3 || code >= 12) return alpha_keep ? "R7" : "R8";
        if (code == 6 || code == 7) return "R4";
        if (code == 8 || code == 9) return "R5";
        return "R10";
    endfunction

    task automatic model_pixel(input logic [7:0] r, g, b, a, input bit eol);
        logic [7:0]  ae;
        logic [31:0] v;
        int n;
        ae = alpha_keep ? (alpha_inv ? ~a : a) : (alpha_inv ? 8'hFF : 8'h00);
        v = ref_bytes(int'(fmt_code), r, g, b, ae);
        n = ref_n(int'(fmt_code));
        for (int j = 0; j < n; j++) bq.push_back(v[8*j +: 8]);
        while (bq.size() >= 4) begin
            logic [31:0] w;
            for (int j = 0; j < 4; j++) w[8*j +: 8] = bq.pop_front();
            exp_data.push_back(w);
            exp_strb.push_back(4'hF & lane_en);
            exp_tag.push_back(fmt_code == 4'd12 && lane_en == 4'hF ? "R2" : full_tag(int'(fmt_code)));
        end
        if (eol && bq.size() > 0) begin
            logic [31:0] w;
            int k;
            k = bq.size();
            w = '0;
            for (int j = 0; j < k; j++) w[8*j +: 8] = bq.pop_front();
            exp_data.push_back(w);
            exp_strb.push_back(4'((1 << k) - 1) & lane_en);
            exp_tag.push_back("R6");
        end
    endtask

    task automatic send_pixel(input logic [7:0] r, g, b, a, input bit eol);
        model_pixel(r, g, b, a, eol);
        if ($urandom % 4 == 0) @(negedge clk);
        @(negedge clk);
        in_red = r; in_green = g; in_blue = b; in_alpha = a; in_eol = eol;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_eol = 1'b0;
    endtask

    task automatic send_line(input int len);
        for (int i = 0; i < len; i++)
            send_pixel(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), i == len - 1);
    endtask

    task automatic drain();
        while (exp_data.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        #2;
        out_ready = hold_ready ? 1'b0 : ($urandom % 4 != 0);
    end

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_data.size() == 0) begin
                check(1'b0, "R10", "unexpected word", out_data, 32'h0);
            end else begin
                logic [31:0] ed;
                logic [3:0]  es;
                string       t;
                ed = exp_data.pop_front();
                es = exp_strb.pop_front();
                t  = exp_tag.pop_front();
                check(out_data == ed, t, "data", out_data, ed);
                check(out_strb == es, t, "strb", {28'h0, out_strb}, {28'h0, es});
            end
        end
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++;
                total++;
                $display("FAIL R11 watchdog expired actual=%0d expected<150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int codes[12] = '{0, 1, 2, 3, 6, 7, 8, 9, 12, 13, 14, 15};
        logic [31:0] d0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0 && err_flag == 1'b0 && in_ready == 1'b1, "R1",
              "reset state", {29'h0, out_valid, err_flag, in_ready}, 32'h1);
        rst = 1'b0;

        // directed: 24-bit, four pixels fill three words (R5)
        fmt_code = 4'd9; alpha_keep = 1'b1; alpha_inv = 1'b0; lane_en = 4'hF;
        send_line(4);
        drain();
        // directed: 24-bit, five pixels leave a 3-byte partial (R6)
        fmt_code = 4'd8;
        send_line(5);
        drain();
        // directed: 16-bit odd line (R3, R6)
        fmt_code = 4'd1; alpha_keep = 1'b0; alpha_inv = 1'b1;
        send_line(3);
        drain();

        // random mix over all formats
        for (int k = 0; k < 72; k++) begin
            fmt_code   = 4'(codes[k % 12]);
            alpha_keep = 1'($urandom);
            alpha_inv  = 1'($urandom);
            lane_en    = (k % 5 == 4) ? 4'($urandom) : 4'hF;
            send_line(1 + ($urandom % 9));
            drain();
        end
        check(err_flag == 1'b0, "R10", "no error on valid codes", {31'h0, err_flag}, 32'h0);

        // R11: stall holds the word and blocks input
        fmt_code = 4'd15; alpha_keep = 1'b1; lane_en = 4'hF;
        hold_ready = 1'b1;
        repeat (2) @(negedge clk);
        send_pixel(8'h11, 8'h22, 8'h33, 8'h44, 1'b1);
        @(negedge clk);
        d0 = out_data;
        check(out_valid == 1'b1, "R11", "valid while stalled", {31'h0, out_valid}, 32'h1);
        in_red = 8'h55; in_green = 8'h66; in_blue = 8'h77; in_alpha = 8'h88; in_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check(in_ready == 1'b0, "R11", "in_ready low in stall", {31'h0, in_ready}, 32'h0);
            check(out_data == d0, "R11", "data held", out_data, d0);
        end
        in_valid = 1'b0;
        hold_ready = 1'b0;
        drain();

        // R10: unused codes produce nothing and set the flag
        fmt_code = 4'd5;
        send_line(3);
        fmt_code = 4'd10;
        send_line(2);
        repeat (10) @(negedge clk);
        check(exp_data.size() == 0, "R10", "no pending words", exp_data.size(), 32'h0);
        check(err_flag == 1'b1, "R10", "flag set", {31'h0, err_flag}, 32'h1);
        fmt_code = 4'd13; alpha_keep = 1'b0; alpha_inv = 1'b0;
        send_line(2);
        drain();
        check(err_flag == 1'b1, "R10", "flag sticky", {31'h0, err_flag}, 32'h1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule